// File: doc/BRIEF.md
# IDEA Encryption Subkey Generator

This block turns a 128-bit cipher key into the 52 sixteen-bit encryption subkeys that an IDEA round datapath uses. The subkeys come out one at a time on a valid/ready stream. The key sits in a 128-bit register. The block first hands out that register's eight 16-bit words, starting with the most significant. It then rotates the whole register left by 25 bit positions and hands out the next eight words. This repeats until 52 subkeys have been delivered. The eight rounds take six subkeys each, and the output transform takes the last four, so the final group is only half used.

A one-cycle load strobe captures a new key and restarts the sequence in that cycle, even if a sequence is still running. The stream follows valid/ready rules. A subkey is transferred on a clock edge where valid and ready are both high. While valid is high and ready is low, the data and index outputs stay frozen, so a consumer can stall for any number of cycles. Once subkey 51 (zero-based) has been accepted, valid drops, a done flag rises, and ready has no effect until the next load.

Top module: `idea_subkey_gen`

## Requirements
- R1: After reset, `sk_valid_o` is 0, `done_o` is 0 and `sk_index_o` is 0, and they stay that way until a load.
- R2: In the cycle after `load_i` is high, `sk_valid_o` is 1, `done_o` is 0, `sk_index_o` is 0 and `sk_data_o` equals `key_i[127:112]`. Load takes priority over a transfer in the same cycle and abandons any sequence in progress.
- R3: Within a group of eight, subkey slot j (0..7) is bits [127-16j : 112-16j] of the current key register, so the most significant word comes first.
- R4: After the eighth subkey of a group (slot 7) is accepted, the key register holds its previous value rotated left by 25 bits. Subkey index i therefore equals word i mod 8 of the loaded key rotated left by 25 times floor(i/8).
- R5: While `sk_valid_o` is 1 and `sk_ready_i` is 0, `sk_data_o`, `sk_index_o` and `sk_valid_o` hold their values on the next cycle.
- R6: `sk_index_o` increases by exactly one per accepted transfer and does not change otherwise, so exactly 52 subkeys (indices 0 to 51) are delivered per load.
- R7: The cycle after index 51 is accepted, `sk_valid_o` is 0 and `done_o` is 1. After that, `sk_ready_i` has no effect: valid stays 0, done stays 1 and the index stays 51 until the next load.
- R8: For any key, the full stream of 52 subkeys matches the rotate-and-slice rule of R3 and R4, whatever pattern of stalls the consumer applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Capture `key_i` and restart the subkey sequence |
| key_i | input | 128 | Cipher key |
| sk_valid_o | output | 1 | Subkey on `sk_data_o` is valid |
| sk_ready_i | input | 1 | Consumer accepts the subkey |
| sk_data_o | output | 16 | Current subkey |
| sk_index_o | output | 6 | Zero-based index of the current subkey |
| done_o | output | 1 | All 52 subkeys delivered |

## Verification
A wrong rotation amount or direction does not show in the first eight subkeys, because those come straight from the loaded key. The first visible symptom is index 8, which is the ninth transfer after a load. A slot or word-order fault shows at index 1, and an index counter fault shows within one transfer as a mismatch between `sk_index_o` and the number of accepted transfers. Termination faults show the cycle after index 51 is accepted, as a missing `done_o` or a lingering `sk_valid_o`. Stall faults show the cycle after ready is held low, as changed data or a changed index.

// File: rtl/isk_pkg.sv
package isk_pkg;
  localparam int unsigned ISK_KEY_W       = 128;
  localparam int unsigned ISK_WORD_W      = 16;
  localparam int unsigned ISK_ROT_BITS    = 25;
  localparam int unsigned ISK_NUM_SUBKEYS = 52;

  typedef struct packed {
    logic fire;
    logic rotate;
  } isk_evt_t;
endpackage

// File: rtl/isk_sequencer.sv
module isk_sequencer
  import isk_pkg::*;
#(
  parameter int unsigned NUM_SK = ISK_NUM_SUBKEYS,
  parameter int unsigned WORDS  = ISK_KEY_W / ISK_WORD_W,
  localparam int unsigned IDX_W  = $clog2(NUM_SK),
  localparam int unsigned SLOT_W = $clog2(WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic              done_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [SLOT_W-1:0] slot_o,
  output isk_evt_t          evt_o
);
  logic              valid_q, done_q;
  logic [IDX_W-1:0]  idx_q;
  logic [SLOT_W-1:0] slot_q;
  logic              last_idx, last_slot;

  // One subkey leaves per handshake; a load in the same cycle wins.
  assign last_idx    = (idx_q == IDX_W'(NUM_SK - 1));
  assign last_slot   = (slot_q == SLOT_W'(WORDS - 1));
  assign evt_o.fire   = valid_q & ready_i & ~load_i;
  assign evt_o.rotate = evt_o.fire & last_slot & ~last_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      idx_q   <= '0;
      slot_q  <= '0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      done_q  <= 1'b0;
      idx_q   <= '0;
      slot_q  <= '0;
    end else if (evt_o.fire) begin
      if (last_idx) begin
        valid_q <= 1'b0;
        done_q  <= 1'b1;
      end else begin
        idx_q  <= idx_q + 1'b1;
        slot_q <= last_slot ? '0 : slot_q + 1'b1;
      end
    end
  end

  assign valid_o = valid_q;
  assign done_o  = done_q;
  assign idx_o   = idx_q;
  assign slot_o  = slot_q;
endmodule

// File: rtl/isk_keyreg.sv
module isk_keyreg
  import isk_pkg::*;
#(
  parameter int unsigned KEY_W    = ISK_KEY_W,
  parameter int unsigned ROT_BITS = ISK_ROT_BITS,
  localparam int unsigned ROT_EFF = ROT_BITS % KEY_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic             rotate_i,
  output logic [KEY_W-1:0] key_o
);
  logic [KEY_W-1:0] key_q, key_rot;

  generate
    if (ROT_EFF == 0) begin : g_no_rot
      assign key_rot = key_q;
    end else begin : g_rot
      assign key_rot = {key_q[KEY_W-ROT_EFF-1:0], key_q[KEY_W-1:KEY_W-ROT_EFF]};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       key_q <= '0;
    else if (load_i)   key_q <= key_i;
    else if (rotate_i) key_q <= key_rot;
  end

  assign key_o = key_q;
endmodule

// File: rtl/isk_slicer.sv
module isk_slicer
  import isk_pkg::*;
#(
  parameter int unsigned KEY_W  = ISK_KEY_W,
  parameter int unsigned WORD_W = ISK_WORD_W,
  localparam int unsigned WORDS  = KEY_W / WORD_W,
  localparam int unsigned SLOT_W = $clog2(WORDS)
) (
  input  logic [KEY_W-1:0]  key_i,
  input  logic [SLOT_W-1:0] slot_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] words [WORDS];

  // Slot 0 is the most significant word.
  for (genvar j = 0; j < WORDS; j++) begin : g_word
    assign words[j] = key_i[KEY_W-1-j*WORD_W -: WORD_W];
  end

  always_comb begin
    word_o = words[0];
    for (int j = 0; j < WORDS; j++) begin
      if (slot_i == SLOT_W'(j)) word_o = words[j];
    end
  end
endmodule

// File: rtl/idea_subkey_gen.sv
module idea_subkey_gen
  import isk_pkg::*;
#(
  parameter int unsigned KEY_W       = ISK_KEY_W,
  parameter int unsigned WORD_W      = ISK_WORD_W,
  parameter int unsigned ROT_BITS    = ISK_ROT_BITS,
  parameter int unsigned NUM_SUBKEYS = ISK_NUM_SUBKEYS,
  localparam int unsigned WORDS  = KEY_W / WORD_W,
  localparam int unsigned IDX_W  = $clog2(NUM_SUBKEYS),
  localparam int unsigned SLOT_W = $clog2(WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [KEY_W-1:0]  key_i,
  output logic              sk_valid_o,
  input  logic              sk_ready_i,
  output logic [WORD_W-1:0] sk_data_o,
  output logic [IDX_W-1:0]  sk_index_o,
  output logic              done_o
);
  logic [SLOT_W-1:0] slot;
  logic [KEY_W-1:0]  key_cur;
  isk_evt_t          evt;

  isk_sequencer #(.NUM_SK(NUM_SUBKEYS), .WORDS(WORDS)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_i),
    .ready_i (sk_ready_i),
    .valid_o (sk_valid_o),
    .done_o  (done_o),
    .idx_o   (sk_index_o),
    .slot_o  (slot),
    .evt_o   (evt)
  );

  isk_keyreg #(.KEY_W(KEY_W), .ROT_BITS(ROT_BITS)) u_key (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load_i),
    .key_i    (key_i),
    .rotate_i (evt.rotate),
    .key_o    (key_cur)
  );

  isk_slicer #(.KEY_W(KEY_W), .WORD_W(WORD_W)) u_slice (
    .key_i  (key_cur),
    .slot_i (slot),
    .word_o (sk_data_o)
  );
endmodule

// File: rtl/idea_subkey_gen_chk.sv
module idea_subkey_gen_chk #(
  parameter int unsigned NUM_SUBKEYS = 52,
  parameter int unsigned IDX_W       = 6,
  parameter int unsigned WORD_W      = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_i,
  input logic              sk_valid_o,
  input logic              sk_ready_i,
  input logic [WORD_W-1:0] sk_data_o,
  input logic [IDX_W-1:0]  sk_index_o,
  input logic              done_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_SUBKEYS - 1);

  assert_load_restart_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (sk_valid_o && !done_o && sk_index_o == '0));

  assert_stall_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sk_valid_o && !sk_ready_i && !load_i) |=>
      (sk_valid_o && $stable(sk_data_o) && $stable(sk_index_o)));

  assert_index_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sk_valid_o && sk_ready_i && !load_i && sk_index_o != LAST) |=>
      (sk_index_o == $past(sk_index_o) + 1'b1));

  assert_index_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sk_index_o <= LAST);

  assert_finish_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sk_valid_o && sk_ready_i && !load_i && sk_index_o == LAST) |=>
      (done_o && !sk_valid_o));

  assert_done_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !load_i) |=> (done_o && !sk_valid_o && $stable(sk_index_o)));

  assert_exclusive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && sk_valid_o));
endmodule

bind idea_subkey_gen idea_subkey_gen_chk #(
  .NUM_SUBKEYS(NUM_SUBKEYS), .IDX_W(IDX_W), .WORD_W(WORD_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .load_i     (load_i),
  .sk_valid_o (sk_valid_o),
  .sk_ready_i (sk_ready_i),
  .sk_data_o  (sk_data_o),
  .sk_index_o (sk_index_o),
  .done_o     (done_o)
);

// File: tb/idea_subkey_gen_bench.sv
module idea_subkey_gen_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load = 1'b0;
  logic [127:0] key = '0;
  logic         ready = 1'b0;
  logic         valid;
  logic [15:0]  data;
  logic [5:0]   index;
  logic         done;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  idea_subkey_gen u_idea_subkey_gen (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .key_i(key),
    .sk_valid_o(valid), .sk_ready_i(ready), .sk_data_o(data),
    .sk_index_o(index), .done_o(done)
  );

  function automatic logic [15:0] model_sk(logic [127:0] k, int i);
    logic [127:0] r = k;
    for (int g = 0; g < i / 8; g++) r = {r[102:0], r[127:103]};
    return r[127 - 16 * (i % 8) -: 16];
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_load(logic [127:0] k);
    @(negedge clk);
    key = k; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  // mode 0: always ready, 1: alternate, 2: pseudo-random stalls
  task automatic drain(logic [127:0] k, int mode, string tag);
    int n = 0;
    int cyc = 0;
    while (n < 52 && cyc < 2000) begin
      logic r;
      chk({tag, " R8 valid"}, 128'(valid), 128'(1));
      chk({tag, " R6 index"}, 128'(index), 128'(n));
      chk({tag, " R3/R4 data"}, 128'(data), 128'(model_sk(k, n)));
      r = (mode == 0) ? 1'b1 : (mode == 1) ? cyc[0] : 1'($urandom_range(0, 2) != 0);
      ready = r;
      if (valid && r) n++;
      cyc++;
      @(negedge clk);
    end
    ready = 1'b0;
    chk({tag, " R7 done"}, 128'(done), 128'(1));
    chk({tag, " R7 valid low"}, 128'(valid), 128'(0));
  endtask

  task automatic t_reset;
    chk("R1 valid", 128'(valid), 128'(0));
    chk("R1 done", 128'(done), 128'(0));
    chk("R1 index", 128'(index), 128'(0));
    ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 valid idle", 128'(valid), 128'(0));
    chk("R1 index idle", 128'(index), 128'(0));
    ready = 1'b0;
  endtask

  task automatic t_first_group;
    logic [127:0] k = 128'h0001_0002_0003_0004_0005_0006_0007_0008;
    do_load(k);
    chk("R2 valid", 128'(valid), 128'(1));
    chk("R2 first word", 128'(data), 128'h0001);
    chk("R2 done low", 128'(done), 128'(0));
    drain(k, 0, "seq");
  endtask

  task automatic t_stall;
    logic [127:0] k = 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210;
    logic [15:0] d0;
    do_load(k);
    ready = 1'b1;
    repeat (3) @(negedge clk);
    ready = 1'b0;
    d0 = data;
    repeat (4) @(negedge clk);
    chk("R5 data held", 128'(data), 128'(d0));
    chk("R5 index held", 128'(index), 128'(3));
    chk("R5 valid held", 128'(valid), 128'(1));
    do_load(k);
    drain(k, 1, "alt");
  endtask

  task automatic t_reload_mid;
    logic [127:0] ka = {$urandom, $urandom, $urandom, $urandom};
    logic [127:0] kb = {$urandom, $urandom, $urandom, $urandom};
    do_load(ka);
    ready = 1'b1;
    repeat (10) @(negedge clk);
    chk("R4 mid index", 128'(index), 128'(10));
    chk("R4 mid data", 128'(data), 128'(model_sk(ka, 10)));
    key = kb; load = 1'b1;
    @(negedge clk);
    load = 1'b0; ready = 1'b0;
    chk("R2 reload index", 128'(index), 128'(0));
    chk("R2 reload data", 128'(data), 128'(kb[127:112]));
    drain(kb, 2, "reload");
  endtask

  task automatic t_after_done;
    ready = 1'b1;
    repeat (5) @(negedge clk);
    chk("R7 done sticky", 128'(done), 128'(1));
    chk("R7 valid stays low", 128'(valid), 128'(0));
    chk("R7 index held", 128'(index), 128'(51));
    ready = 1'b0;
    do_load(128'hdead_beef_0000_1111_2222_3333_4444_5555);
    chk("R2 done cleared", 128'(done), 128'(0));
    chk("R2 valid after done", 128'(valid), 128'(1));
  endtask

  task automatic t_random_keys;
    for (int t = 0; t < 4; t++) begin
      logic [127:0] k = {$urandom, $urandom, $urandom, $urandom};
      do_load(k);
      drain(k, 2, "rand R8");
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_group();
    t_stall();
    t_reload_mid();
    t_after_done();
    t_random_keys();
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule